// File: doc/BRIEF.md
# Local/Global Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two predictors. The local one keeps a separate history for each branch, and that history selects a 3-bit saturating counter. The global one uses the outcomes of the most recent branches to select a 2-bit saturating counter. A chooser table of 2-bit counters, indexed by the global history, decides which of the two supplies the final answer.

A lookup is purely combinational on the fetch PC. The block returns the final taken bit and also the bit from each component. The front end keeps both component bits with the branch. When the branch resolves, the back end returns the PC, the real outcome and those saved bits. All tables and histories are then updated on that clock edge.

Top module: `bpTournament`

## Requirements
- R1: After reset every local and global counter sits at its weakly-not-taken value (3 for local, 1 for global), all histories are zero and every chooser entry is 1, so every PC predicts not taken on all three outputs.
- R2: The local history entry is selected by PC bits [LIDX_W+1:2], which is [11:2] by default. PC bits outside that field have no effect on the lookup.
- R3: A local counter is 3 bits wide and saturates at 0 and 7. It predicts taken when its value is 4 or more. It is selected by the branch's local history entry, which is 10 bits by default.
- R4: A global counter is 2 bits wide and saturates at 0 and 3. It predicts taken when its value is 2 or more. It is selected only by the global history of GHIST_W outcomes (12 by default), so the global prediction does not depend on the fetch PC.
- R5: On a resolve, the outcome (1 = taken) shifts into bit 0 of the resolved branch's local history entry and into bit 0 of the global history. The counters are trained using the histories as they were before the shift.
- R6: The final prediction equals the global prediction when bit 1 of the chooser entry at the current global history is set. Otherwise it equals the local prediction.
- R7: A chooser entry changes only on a resolve whose saved local and global predictions differ. It counts up (saturating at 3) if the global one matched the outcome, and down (saturating at 0) if the local one did.
- R8: Predictions do not change in a cycle in which no resolve was applied at the previous edge. A resolve takes effect at the clock edge, so a lookup in the same cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | PC being looked up |
| predTaken | output | 1 | Final predicted direction |
| predLocal | output | 1 | Local component's prediction |
| predGlobal | output | 1 | Global component's prediction |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_W | PC of the resolving branch |
| resTaken | input | 1 | Real outcome, 1 = taken |
| resLocalPred | input | 1 | Local prediction saved at lookup |
| resGlobalPred | input | 1 | Global prediction saved at lookup |

## Verification
The assertions check on every cycle that the final bit is always one of the two component bits. They also check that the predictions hold still when no resolve has landed, that the global bit ignores the fetch PC between resolves, and that the first cycle after reset predicts not taken. The bench's scenarios are the only way to show counter saturation, the history shifting and the PC field that is used, chooser training that happens only on disagreement, and same-cycle lookups that still see the old state. It does this by running a small configuration through long sequences and comparing the results with an arithmetic model of the requirements.

// File: rtl/bpTournamentPkg.sv
package bpTournamentPkg;

  typedef struct packed {
    logic trainTables;   // train counters and shift histories
    logic outcome;       // value shifted in / counter direction
    logic trainChoice;   // components disagreed
    logic choiceUp;      // global was right
  } bpStrobeT;

  function automatic logic [2:0] sat3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    else    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  function automatic logic [1:0] sat2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

endpackage

// File: rtl/bpTournamentCtrl.sv
module bpTournamentCtrl
  import bpTournamentPkg::*;
(
  input  logic     resValid,
  input  logic     resTaken,
  input  logic     resLocalPred,
  input  logic     resGlobalPred,
  output bpStrobeT strobe
);
  always_comb begin
    strobe.trainTables = resValid;
    strobe.outcome     = resTaken;
    strobe.trainChoice = resValid && (resLocalPred != resGlobalPred);
    strobe.choiceUp    = (resGlobalPred == resTaken);
  end
endmodule

// File: rtl/bpTournamentDp.sv
module bpTournamentDp
  import bpTournamentPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] resPc,
  input  bpStrobeT        strobe,
  output logic            predLocal,
  output logic            predGlobal,
  output logic            useGlobal
);
  localparam int LHT_N = 1 << LIDX_W;
  localparam int LPT_N = 1 << LHIST_W;
  localparam int GPT_N = 1 << GHIST_W;

  logic [LHIST_W-1:0] localHist [LHT_N];
  logic [2:0]         localCnt  [LPT_N];
  logic [1:0]         globalCnt [GPT_N];
  logic [1:0]         choiceCnt [GPT_N];
  logic [GHIST_W-1:0] globalHist;

  logic [LIDX_W-1:0]  fetchIdx, resIdx;
  logic [LHIST_W-1:0] fetchHist, resHist;

  assign fetchIdx  = fetchPc[LIDX_W+1:2];
  assign resIdx    = resPc[LIDX_W+1:2];
  assign fetchHist = localHist[fetchIdx];
  assign resHist   = localHist[resIdx];

  assign predLocal  = localCnt[fetchHist][2];
  assign predGlobal = globalCnt[globalHist][1];
  assign useGlobal  = choiceCnt[globalHist][1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LHT_N; i++) localHist[i] <= '0;
      for (int i = 0; i < LPT_N; i++) localCnt[i]  <= 3'd3;
      for (int i = 0; i < GPT_N; i++) begin
        globalCnt[i] <= 2'd1;
        choiceCnt[i] <= 2'd1;
      end
      globalHist <= '0;
    end else if (strobe.trainTables) begin
      localCnt[resHist]     <= sat3(localCnt[resHist], strobe.outcome);
      globalCnt[globalHist] <= sat2(globalCnt[globalHist], strobe.outcome);
      if (strobe.trainChoice)
        choiceCnt[globalHist] <= sat2(choiceCnt[globalHist], strobe.choiceUp);
      localHist[resIdx] <= {resHist[LHIST_W-2:0], strobe.outcome};
      globalHist        <= {globalHist[GHIST_W-2:0], strobe.outcome};
    end
  end
endmodule

// File: rtl/bpTournament.sv
module bpTournament
  import bpTournamentPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic            resLocalPred,
  input  logic            resGlobalPred
);
  bpStrobeT strobe;
  logic     useGlobal;

  bpTournamentCtrl u_ctrl (
    .resValid     (resValid),
    .resTaken     (resTaken),
    .resLocalPred (resLocalPred),
    .resGlobalPred(resGlobalPred),
    .strobe       (strobe)
  );

  bpTournamentDp #(
    .PC_W(PC_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchPc   (fetchPc),
    .resPc     (resPc),
    .strobe    (strobe),
    .predLocal (predLocal),
    .predGlobal(predGlobal),
    .useGlobal (useGlobal)
  );

  assign predTaken = useGlobal ? predGlobal : predLocal;
endmodule

// File: rtl/bpTournamentChk.sv
module bpTournamentChk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic            predTaken,
  input logic            predLocal,
  input logic            predGlobal,
  input logic            resValid
);
  // R6: the final bit always comes from one of the components
  assert_final_from_component_R6: assert property (@(posedge clk) disable iff (!rstN)
    (predTaken == predLocal) || (predTaken == predGlobal));

  // R8: with no resolve at the last edge and the same PC, nothing moves
  assert_stable_without_resolve_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(resValid) && $stable(fetchPc)) |-> ($stable(predLocal) && $stable(predTaken)));

  // R4: global bit ignores the fetch PC between resolves
  assert_global_pc_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(resValid) |-> $stable(predGlobal));

  // R1: first cycle out of reset predicts not taken everywhere
  assert_reset_not_taken_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!predTaken && !predLocal && !predGlobal));
endmodule

bind bpTournament bpTournamentChk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchPc   (fetchPc),
  .predTaken (predTaken),
  .predLocal (predLocal),
  .predGlobal(predGlobal),
  .resValid  (resValid)
);

// File: tb/bpTournament_bench.sv
module bpTournament_bench;
  localparam int PC_W = 32;
  localparam int LI   = 4;
  localparam int LH   = 4;
  localparam int GH   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic predTaken, predLocal, predGlobal;
  logic resValid = 1'b0;
  logic [PC_W-1:0] resPc = '0;
  logic resTaken = 1'b0, resLocalPred = 1'b0, resGlobalPred = 1'b0;

  always #10 clk = ~clk;

  bpTournament #(.PC_W(PC_W), .LIDX_W(LI), .LHIST_W(LH), .GHIST_W(GH)) u_bpTournament (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken),
    .resLocalPred(resLocalPred), .resGlobalPred(resGlobalPred)
  );

  int nRun = 0, nFail = 0;
  logic [LH-1:0] mLht [1<<LI];
  logic [2:0]    mLpt [1<<LH];
  logic [1:0]    mGpt [1<<GH];
  logic [1:0]    mCht [1<<GH];
  logic [GH-1:0] mGhr;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkPreds(input logic [PC_W-1:0] pc, input string tag);
    logic [LH-1:0] h;
    logic eL, eG, eT;
    h  = mLht[pc[LI+1:2]];
    eL = (mLpt[h] >= 3'd4);
    eG = (mGpt[mGhr] >= 2'd2);
    eT = mCht[mGhr][1] ? eG : eL;
    chk({"R3 local ", tag}, predLocal, eL);
    chk({"R4 global ", tag}, predGlobal, eG);
    chk({"R6/R7 final ", tag}, predTaken, eT);
  endtask

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input logic t,
                             input logic rl, input logic rg);
    logic [LI-1:0] li;
    logic [LH-1:0] h;
    li = pc[LI+1:2];
    h  = mLht[li];
    if (t) begin if (mLpt[h] != 3'd7) mLpt[h] = mLpt[h] + 3'd1; end
    else   begin if (mLpt[h] != 3'd0) mLpt[h] = mLpt[h] - 3'd1; end
    if (t) begin if (mGpt[mGhr] != 2'd3) mGpt[mGhr] = mGpt[mGhr] + 2'd1; end
    else   begin if (mGpt[mGhr] != 2'd0) mGpt[mGhr] = mGpt[mGhr] - 2'd1; end
    if (rl != rg) begin
      if (rg == t) begin if (mCht[mGhr] != 2'd3) mCht[mGhr] = mCht[mGhr] + 2'd1; end
      else         begin if (mCht[mGhr] != 2'd0) mCht[mGhr] = mCht[mGhr] - 2'd1; end
    end
    mLht[li] = {h[LH-2:0], t};
    mGhr     = {mGhr[GH-2:0], t};
  endtask

  // lookup, resolve the same branch, check the same-cycle view, apply edge
  task automatic step(input logic [PC_W-1:0] pc, input logic t, input logic flip,
                      input string tag);
    logic sl, sg;
    @(negedge clk);
    fetchPc = pc;
    #1;
    checkPreds(pc, tag);
    sl = predLocal ^ flip;
    sg = predGlobal;
    resPc = pc; resTaken = t; resLocalPred = sl; resGlobalPred = sg;
    resValid = 1'b1;
    #1;
    checkPreds(pc, "R8 same-cycle");
    @(posedge clk);
    modelUpdate(pc, t, sl, sg);
    @(negedge clk);
    resValid = 1'b0;
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #2_000_000;
    nFail++; nRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<LI); i++) mLht[i] = '0;
    for (int i = 0; i < (1<<LH); i++) mLpt[i] = 3'd3;
    for (int i = 0; i < (1<<GH); i++) begin mGpt[i] = 2'd1; mCht[i] = 2'd1; end
    mGhr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every index not taken after reset
    for (int i = 0; i < (1<<LI); i++) begin
      @(negedge clk);
      fetchPc = {20'h12345, 6'd0, i[3:0], 2'b00};
      #1;
      chk("R1 local", predLocal, 1'b0);
      chk("R1 global", predGlobal, 1'b0);
      chk("R1 final", predTaken, 1'b0);
    end

    // R3: saturate a local counter upward, then another downward
    for (int i = 0; i < 12; i++) step(32'h0000_0010, 1'b1, 1'b0, "R3 sat-up");
    for (int i = 0; i < 12; i++) step(32'h0000_0024, 1'b0, 1'b0, "R3 sat-down");

    // R7: forced disagreement in both directions trains the chooser
    for (int i = 0; i < 10; i++) step(32'h0000_0008, 1'b1, 1'b1, "R7 toward-global");
    for (int i = 0; i < 10; i++) step(32'h0000_0008, 1'b0, 1'b1, "R7 toward-local");

    // R5/R6: pseudo-random sweep over all indices and outcomes
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] pc;
      lfsr = nextLfsr(lfsr);
      pc = {lfsr[15:8], 18'd0, lfsr[3:0], 2'b00} ^ {lfsr, 16'd0};
      pc[1:0] = 2'b00;
      step(pc, lfsr[4] ^ lfsr[9], (i % 5) == 0, "R5 sweep");
    end

    // R2: high PC bits and low two bits do not change the lookup
    for (int i = 0; i < (1<<LI); i++) begin
      logic [PC_W-1:0] pc;
      pc = {10'h3A5, 16'hBEEF, i[3:0], 2'b11};
      @(negedge clk);
      fetchPc = pc;
      #1;
      checkPreds(pc, "R2 alias");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule